// File: doc/BRIEF.md
# Shared Add/Multiply Arithmetic Unit

This unit computes one of sixteen functions on a shared datapath that holds a single adder and a single multiplier. A 4-bit control word sets up three multiplexers and one post-processing choice. The first operand comes from input A or input B. The second operand comes from input C or input D. The kernel then produces either the sum or the product. The result is either truncated to 16 bits or clamped to the 16-bit range. The operands are read as signed two's-complement or as unsigned values, depending on a mode input.

The arithmetic is combinational. One output register captures the result and the overflow indication whenever the valid input is high, so results appear one clock after they are presented. An overflow output reports when the full-precision kernel result does not fit in 16 bits. It does this in both the truncating mode and the clamping mode.

Top module: `muxdp_unit`

## Requirements
- R1: ctrl[0] picks the first operand: 0 takes opnd_a and 1 takes opnd_b.
- R2: ctrl[1] picks the second operand: 0 takes opnd_c and 1 takes opnd_d.
- R3: ctrl[2] picks the kernel: 0 adds the two operands and 1 multiplies them, at full precision.
- R4: With ctrl[3] = 0, result is the low 16 bits of the full-precision kernel value, whether or not it overflows.
- R5: With ctrl[3] = 1 and sgn_mode = 1, an out-of-range value clamps to 16'h7FFF if it is positive and to 16'h8000 if it is negative. A value in range passes unchanged.
- R6: With ctrl[3] = 1 and sgn_mode = 0 (operands zero-extended), a value above 65535 clamps to 16'hFFFF. A value in range passes unchanged.
- R7: ovf is 1 exactly when the full-precision value lies outside [-32768, 32767] in signed mode, or outside [0, 65535] in unsigned mode. This holds regardless of ctrl[3].
- R8: A transaction presented with in_valid = 1 at a rising edge appears on result and ovf after that edge, with out_valid = 1 for that one cycle.
- R9: While in_valid = 0, out_valid is 0 and result and ovf keep their last captured values, whatever the operand, control and mode inputs do.
- R10: During and after reset, out_valid, result and ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture the current operation at this edge |
| sgn_mode | input | 1 | 1 = signed operands, 0 = unsigned operands |
| ctrl | input | 4 | [0] A/B select, [1] C/D select, [2] add/multiply, [3] saturate |
| opnd_a | input | 16 | First-operand candidate A |
| opnd_b | input | 16 | First-operand candidate B |
| opnd_c | input | 16 | Second-operand candidate C |
| opnd_d | input | 16 | Second-operand candidate D |
| out_valid | output | 1 | Registered result is fresh this cycle |
| result | output | 16 | Registered 16-bit result |
| ovf | output | 1 | Registered overflow indication |

## Verification
The only state is the output register and the valid bit, so a fault shows on the ports within one cycle of the transaction that exposes it. A wrong operand select, kernel select or sign extension gives a wrong result value on the very next out_valid. A wrong clamp bound or range test shows as a wrong ovf or a wrong clamped value on the first out-of-range operation. That is why the stimulus sweeps all sixteen control codes in both modes and aims directly at the range edges. A register that updates without in_valid shows on the first idle cycle in which the inputs change.

// File: rtl/muxdp_pkg.sv
package muxdp_pkg;
  // Control word layout; bit order is the port encoding.
  typedef struct packed {
    logic sat;    // [3] clamp to 16-bit range
    logic mul;    // [2] 0 = add, 1 = multiply
    logic sel_d;  // [1] 0 = C, 1 = D
    logic sel_b;  // [0] 0 = A, 1 = B
  } mx_ctrl_t;
endpackage

// File: rtl/muxdp_presel.sv
module muxdp_presel #(
  parameter int DW = 16,
  localparam int EW = DW + 1
) (
  input  logic          sgn,
  input  logic          sel_b,
  input  logic          sel_d,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic [DW-1:0] d,
  output logic [EW-1:0] x_ext,
  output logic [EW-1:0] y_ext
);
  // One guard bit: sign copy in signed mode, zero in unsigned mode.
  function automatic logic [EW-1:0] extend(input logic s, input logic [DW-1:0] v);
    return {s & v[DW-1], v};
  endfunction

  logic [DW-1:0] x_pick, y_pick;
  assign x_pick = sel_b ? b : a;
  assign y_pick = sel_d ? d : c;
  assign x_ext  = extend(sgn, x_pick);
  assign y_ext  = extend(sgn, y_pick);
endmodule

// File: rtl/muxdp_kernel.sv
module muxdp_kernel #(
  parameter int DW = 16,
  localparam int EW = DW + 1,
  localparam int KW = 2 * EW
) (
  input  logic                 mul,
  input  logic [EW-1:0]        x_ext,
  input  logic [EW-1:0]        y_ext,
  output logic signed [KW-1:0] wide
);
  function automatic logic signed [KW-1:0] widen(input logic [EW-1:0] v);
    return {{(KW-EW){v[EW-1]}}, v};
  endfunction

  logic signed [KW-1:0] xw, yw, sum_w, prod_w;
  assign xw     = widen(x_ext);
  assign yw     = widen(y_ext);
  assign sum_w  = xw + yw;
  assign prod_w = xw * yw;
  assign wide   = mul ? prod_w : sum_w;
endmodule

// File: rtl/muxdp_post.sv
module muxdp_post #(
  parameter int DW = 16,
  localparam int KW = 2 * (DW + 1)
) (
  input  logic                 sgn,
  input  logic                 sat,
  input  logic signed [KW-1:0] wide,
  output logic [DW-1:0]        res,
  output logic                 ovf
);
  localparam logic signed [KW-1:0] SMAX = {{(KW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [KW-1:0] SMIN = {{(KW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [KW-1:0] UMAX = {{(KW-DW){1'b0}}, {DW{1'b1}}};

  function automatic logic out_of_range(input logic s, input logic signed [KW-1:0] v);
    if (s) return (v > SMAX) || (v < SMIN);
    return (v > UMAX) || (v < 0);
  endfunction

  function automatic logic [DW-1:0] clamp_val(input logic s, input logic signed [KW-1:0] v);
    if (v < 0) return s ? {1'b1, {(DW-1){1'b0}}} : {DW{1'b0}};
    return s ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
  endfunction

  assign ovf = out_of_range(sgn, wide);
  assign res = (sat && ovf) ? clamp_val(sgn, wide) : wide[DW-1:0];
endmodule

// File: rtl/muxdp_unit.sv
module muxdp_unit #(
  parameter int DW = 16,
  localparam int EW = DW + 1,
  localparam int KW = 2 * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          sgn_mode,
  input  logic [3:0]    ctrl,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] opnd_c,
  input  logic [DW-1:0] opnd_d,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          ovf
);
  import muxdp_pkg::*;

  mx_ctrl_t             cw;
  logic [EW-1:0]        x_ext, y_ext;
  logic signed [KW-1:0] kern_wide;
  logic [DW-1:0]        post_res;
  logic                 ovf_c;

  assign cw = mx_ctrl_t'(ctrl);

  muxdp_presel #(.DW(DW)) u_pre (
    .sgn(sgn_mode), .sel_b(cw.sel_b), .sel_d(cw.sel_d),
    .a(opnd_a), .b(opnd_b), .c(opnd_c), .d(opnd_d),
    .x_ext(x_ext), .y_ext(y_ext)
  );

  muxdp_kernel #(.DW(DW)) u_kern (
    .mul(cw.mul), .x_ext(x_ext), .y_ext(y_ext), .wide(kern_wide)
  );

  muxdp_post #(.DW(DW)) u_post (
    .sgn(sgn_mode), .sat(cw.sat), .wide(kern_wide),
    .res(post_res), .ovf(ovf_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= post_res;
        ovf    <= ovf_c;
      end
    end
  end
endmodule

// File: rtl/muxdp_unit_chk.sv
module muxdp_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          sgn_mode,
  input logic [3:0]    ctrl,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          ovf,
  input logic [DW-1:0] kern_low,
  input logic          ovf_c
);
  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ovf)));

  p_raw_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ctrl[3]) |=> (result == $past(kern_low)));

  p_sgn_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[3] && sgn_mode && ovf_c) |=>
      (result == {1'b0, {(DW-1){1'b1}}} || result == {1'b1, {(DW-1){1'b0}}}));

  p_uns_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[3] && !sgn_mode && ovf_c) |=> (result == {DW{1'b1}}));

  p_no_ovf_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovf_c) |=> (!ovf && result == $past(kern_low)));
endmodule

bind muxdp_unit muxdp_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sgn_mode(sgn_mode),
  .ctrl(ctrl), .out_valid(out_valid), .result(result), .ovf(ovf),
  .kern_low(kern_wide[DW-1:0]), .ovf_c(ovf_c)
);

// File: tb/muxdp_unit_bench.sv
module muxdp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        sgn_mode = 1'b0;
  logic [3:0]  ctrl = 4'h0;
  logic [15:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, opnd_d = '0;
  logic        out_valid, ovf;
  logic [15:0] result;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] seed = 32'h1234_5679;

  always #5 clk = ~clk;

  muxdp_unit u_muxdp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sgn_mode(sgn_mode),
    .ctrl(ctrl), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .opnd_d(opnd_d), .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  // Reference model in wide integers, independent of the design structure.
  function automatic logic [16:0] model(input logic [3:0] cw, input logic s,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c, input logic [15:0] d);
    logic [15:0] xv, yv;
    longint x, y, full;
    logic o;
    logic [15:0] r;
    xv = cw[0] ? b : a;
    yv = cw[1] ? d : c;
    x = s ? longint'($signed(xv)) : longint'(xv);
    y = s ? longint'($signed(yv)) : longint'(yv);
    full = cw[2] ? x * y : x + y;
    o = s ? (full > 32767 || full < -32768) : (full > 65535 || full < 0);
    r = full[15:0];
    if (cw[3] && o) r = s ? (full < 0 ? 16'h8000 : 16'h7FFF) : (full < 0 ? 16'h0000 : 16'hFFFF);
    return {o, r};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] cw, input logic s, input logic [15:0] a,
      input logic [15:0] b, input logic [15:0] c, input logic [15:0] d, input string tag);
    @(negedge clk);
    ctrl = cw; sgn_mode = s; opnd_a = a; opnd_b = b; opnd_c = c; opnd_d = d;
    in_valid = 1'b1;
    exp_q.push_back(model(cw, s, a, b, c, d));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Scoreboard monitor: one expected item per out_valid cycle (R8).
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected out_valid", 32'(result), 32'h0);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({ovf, result} == e, t, 32'({ovf, result}), 32'(e));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && result == 16'h0 && !ovf, "R10 reset", 32'({out_valid, ovf, result}), 32'h0);
    rst_n = 1'b1;

    // Operand selection R1/R2 and kernel R3, in-range values
    send(4'b0000, 1'b0, 16'd10, 16'd20, 16'd3, 16'd4, "R1 R2 R3 A+C");
    send(4'b0001, 1'b0, 16'd10, 16'd20, 16'd3, 16'd4, "R1 B+C");
    send(4'b0010, 1'b0, 16'd10, 16'd20, 16'd3, 16'd4, "R2 A+D");
    send(4'b0111, 1'b0, 16'd10, 16'd20, 16'd3, 16'd4, "R3 B*D");
    send(4'b0100, 1'b1, 16'hFFF6, 16'd1, 16'd7, 16'd0, "R3 signed A*C");
    // Raw truncation R4 with overflow flag R7
    send(4'b0000, 1'b0, 16'hFFFF, 16'h0, 16'h0001, 16'h0, "R4 R7 uns wrap add");
    send(4'b0100, 1'b1, 16'h8000, 16'h0, 16'h8000, 16'h0, "R4 R7 sgn wrap mul");
    // Signed clamp R5
    send(4'b1000, 1'b1, 16'h7FFF, 16'h0, 16'h0001, 16'h0, "R5 clamp high");
    send(4'b1000, 1'b1, 16'h8000, 16'h0, 16'hFFFF, 16'h0, "R5 clamp low");
    send(4'b1100, 1'b1, 16'h8000, 16'h0, 16'h8000, 16'h0, "R5 clamp mul");
    send(4'b1000, 1'b1, 16'h7FFE, 16'h0, 16'h0001, 16'h0, "R5 R7 edge no ovf");
    send(4'b1100, 1'b1, 16'h8000, 16'h0, 16'h0001, 16'h0, "R5 R7 min no ovf");
    // Unsigned clamp R6
    send(4'b1000, 1'b0, 16'hFFFF, 16'h0, 16'h0001, 16'h0, "R6 clamp add");
    send(4'b1100, 1'b0, 16'h0100, 16'h0, 16'h0100, 16'h0, "R6 clamp mul");
    send(4'b1100, 1'b0, 16'h00FF, 16'h0, 16'h0101, 16'h0, "R6 R7 edge no ovf");
    send(4'b1111, 1'b0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, "R6 max mul");

    // Sweep every control code in both modes (R1 to R7)
    for (int k = 0; k < 256; k++) begin
      logic [31:0] r1, r2;
      r1 = nxt(); r2 = nxt();
      send(4'(k), k[4], r1[15:0], r1[31:16], r2[15:0], r2[31:16],
           k[3] ? (k[4] ? "R5 sweep" : "R6 sweep") : "R4 R7 sweep");
    end
    idle();
    @(negedge clk);

    // Idle hold R9
    send(4'b0000, 1'b0, 16'd100, 16'd0, 16'd23, 16'd0, "R9 setup");
    idle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ctrl = 4'(k + 5); sgn_mode = ~sgn_mode;
      opnd_a = 16'hFFFF; opnd_b = 16'h1234; opnd_c = 16'hFFFF; opnd_d = 16'h8000;
      #1;
      check(!out_valid && result == 16'd123 && !ovf, "R9 hold",
            32'({out_valid, ovf, result}), 32'd123);
    end
    repeat (2) @(negedge clk);
    #1;
    check(exp_q.size() == 0, "R8 all results seen", 32'(exp_q.size()), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule